// File: doc/BRIEF.md
# Step Attenuator Programming Master

This block sits on the host side of a 6-bit RF step attenuator and turns a requested attenuation code into the pin waveforms the attenuator expects. A code is handed over with a valid/ready handshake. The block then either shifts the code out on a serial clock/data pair and closes with a latch pulse, or drives the code on a 6-bit bus and strobes the same latch line. The choice between the two forms is made per request.

Every timing minimum on the attenuator pins is met by counting cycles of the system clock. The clock period and each minimum time are parameters. Each time is rounded up to whole cycles, and no phase is shorter than one cycle. An optional hold-off after each latch pulse keeps updates at or below 25 kHz. This is needed when the attenuator generates its own negative supply.

Mode and hold-off are static configuration inputs, captured when a request is accepted. A request that arrives while an update is in flight waits for ready and is not lost.

Top module: `atten_prog_master`

## Requirements
- R1: After reset, and whenever no update is in flight, `req_ready` is 1 and `ser_clk` and `latch_en` are 0. Directly after reset `ser_data` is 0 and `par_bus` is 0.
- R2: A request is taken on the clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the update, including any hold-off, is complete. A request held while busy stays pending and is taken as soon as `req_ready` returns. The code is the value on `req_code` at acceptance.
- R3: In serial mode (`cfg_parallel`=0) the six code bits go out most significant first: bit 5, the 16 dB weight, first and bit 0, the 0.5 dB weight, last. There is one `ser_clk` rising edge per bit, and the first bit is on `ser_data` in the cycle after acceptance.
- R4: `ser_clk` high time is ceil(max(30 ns, data hold 10 ns)/period) cycles. Low time before each rise is the largest of ceil(30 ns/period), ceil(10 ns setup/period) and ceil(100 ns/period) minus the high time. At the default 20 ns period this is 2 cycles high and 3 low, giving a 100 ns clock period.
- R5: `ser_data` changes only at the start of an update or at a `ser_clk` falling edge. It is stable for the whole high phase and for the cycle before each rise.
- R6: `latch_en` stays 0 while `ser_clk` toggles. It rises ceil(10 ns/period) cycles after the last `ser_clk` falling edge, which is at least that long after the last rising edge.
- R7: In serial mode the latch pulse lasts ceil(30 ns/period) cycles (2 by default) and then returns to 0.
- R8: In latched parallel mode (`cfg_parallel`=1), `par_bus` carries the code from the cycle after acceptance. `latch_en` rises after ceil(10 ns/period) setup cycles and stays high ceil(10 ns/period) cycles. `ser_clk` stays 0 throughout.
- R9: When `cfg_gap_en` was 1 at acceptance, `req_ready` stays 0 for ceil(40 us/period) cycles (2000 by default) after the latch-low or parallel hold phase. This keeps successive latch pulses at least that far apart.
- R10: Without hold-off, `req_ready` returns in the cycle `latch_en` falls in serial mode. In parallel mode it returns after a hold phase of ceil(10 ns/period) cycles (1 by default), during which `par_bus` is unchanged.
- R11: Changes on `cfg_parallel`, `cfg_gap_en` and `req_code` while an update is in flight have no effect on that update.
- R12: A serial update leaves `par_bus` at its previous value. A parallel update leaves `ser_data` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_code | input | 6 | Requested attenuation code, bit 0 = 0.5 dB |
| cfg_parallel | input | 1 | 1 = latched parallel, 0 = serial; taken at acceptance |
| cfg_gap_en | input | 1 | 1 = enforce update hold-off; taken at acceptance |
| req_ready | output | 1 | Block can accept a request |
| ser_clk | output | 1 | Serial clock to attenuator, idles low |
| ser_data | output | 1 | Serial data to attenuator |
| latch_en | output | 1 | Latch strobe to attenuator, idles low |
| par_bus | output | 6 | Parallel code bus to attenuator |

## Verification
Every pin result is due at a fixed offset from the acceptance edge. The first serial bit and the parallel bus appear one cycle after acceptance. Each `ser_clk` rise comes 3 cycles after its bit is placed and each fall 2 cycles after that. The latch rises 1 cycle after the last fall and is low again 2 cycles later in serial mode, or 1 cycle later in parallel mode. `req_ready` returns 0, 1, 2000 or 2001 cycles after the latch falls, depending on mode and hold-off.

The bench extends a per-cycle expectation queue at the clock edge it predicts will accept a request. It samples on the falling clock edge, so each popped entry lines up with the cycle its registered output is due. Separate counters measure the ready-return latency and rebuild the shifted word at each latch rise.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOW,
      ST_SHIGH,
      ST_LESU,
      ST_LEHI,
      ST_PSU,
      ST_PHOLD,
      ST_GAP
   } prog_st_t;

   // minimum time in ns -> whole clock cycles, rounded up, at least one
   function automatic int cyc_of(input int t_ns, input int per_ns);
      int c;
      c = (t_ns + per_ns - 1) / per_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/atten_span_timer.sv
module atten_span_timer #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= load_val;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/atten_bit_shifter.sv
module atten_bit_shifter #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] code,
   input  logic         shift,
   output logic         bit_out,
   output logic         last
);
   localparam int CW = (W > 1) ? $clog2(W) : 1;

   logic [W-1:0]  sreg;
   logic [CW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
      end else if (load) begin
         sreg <= code;
         left <= CW'(W - 1);
      end else if (shift) begin
         sreg <= {sreg[W-2:0], 1'b0};
         left <= left - 1'b1;
      end
   end

   assign bit_out = sreg[W-1];
   assign last    = (left == '0);
endmodule

// File: rtl/atten_prog_master.sv
module atten_prog_master
   import atten_prog_pkg::*;
#(
   parameter int CODE_W          = 6,
   parameter int CLK_PERIOD_NS   = 20,
   parameter int SCLK_HI_NS      = 30,
   parameter int SCLK_LO_NS      = 30,
   parameter int SCLK_PERIOD_NS  = 100,
   parameter int SDATA_SETUP_NS  = 10,
   parameter int SDATA_HOLD_NS   = 10,
   parameter int LE_AFTER_CLK_NS = 10,
   parameter int SER_LE_PW_NS    = 30,
   parameter int PAR_SETUP_NS    = 10,
   parameter int PAR_LE_PW_NS    = 10,
   parameter int PAR_HOLD_NS     = 10,
   parameter int UPDATE_GAP_NS   = 40000,
   parameter bit HAS_PARALLEL    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CODE_W-1:0] req_code,
   input  logic              cfg_parallel,
   input  logic              cfg_gap_en,
   output logic              req_ready,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              latch_en,
   output logic [CODE_W-1:0] par_bus
);
   localparam int P      = CLK_PERIOD_NS;
   localparam int HI_C   = imax(cyc_of(SCLK_HI_NS, P), cyc_of(SDATA_HOLD_NS, P));
   localparam int LO_C   = imax(imax(cyc_of(SCLK_LO_NS, P), cyc_of(SDATA_SETUP_NS, P)),
                                cyc_of(SCLK_PERIOD_NS, P) - HI_C);
   localparam int LESU_C = cyc_of(LE_AFTER_CLK_NS, P);
   localparam int SLE_C  = cyc_of(SER_LE_PW_NS, P);
   localparam int PSU_C  = cyc_of(PAR_SETUP_NS, P);
   localparam int PLE_C  = cyc_of(PAR_LE_PW_NS, P);
   localparam int PHD_C  = cyc_of(PAR_HOLD_NS, P);
   localparam int GAP_C  = cyc_of(UPDATE_GAP_NS, P);
   localparam int MAX_C  = imax(imax(imax(HI_C, LO_C), imax(LESU_C, SLE_C)),
                                imax(imax(PSU_C, PLE_C), imax(PHD_C, GAP_C)));
   localparam int TW     = imax(1, $clog2(MAX_C));

   if (CODE_W < 2) begin : g_bad_width
      $error("CODE_W must be at least 2");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("CLK_PERIOD_NS must be positive");
   end

   prog_st_t      st, st_n;
   logic          accept, par_eff;
   logic          mode_par_q, gap_q;
   logic          t_load, t_exp;
   logic [TW-1:0] t_val;
   logic          sh_load, sh_shift, sh_last;
   logic          sclk_q, le_q;

   assign req_ready = (st == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign sh_load   = accept && !par_eff;

   if (HAS_PARALLEL) begin : g_par
      logic [CODE_W-1:0] bus_q;
      assign par_eff = cfg_parallel;
      always_ff @(posedge clk) begin
         if (!rst_n)                 bus_q <= '0;
         else if (accept && par_eff) bus_q <= req_code;
      end
      assign par_bus = bus_q;
   end else begin : g_ser_only
      assign par_eff = 1'b0;
      assign par_bus = '0;
   end

   always_comb begin
      st_n     = st;
      t_load   = 1'b0;
      t_val    = '0;
      sh_shift = 1'b0;
      unique case (st)
         ST_IDLE: if (accept) begin
            t_load = 1'b1;
            if (par_eff) begin st_n = ST_PSU;  t_val = TW'(PSU_C - 1); end
            else         begin st_n = ST_SLOW; t_val = TW'(LO_C - 1);  end
         end
         ST_SLOW: if (t_exp) begin
            st_n = ST_SHIGH; t_load = 1'b1; t_val = TW'(HI_C - 1);
         end
         ST_SHIGH: if (t_exp) begin
            t_load = 1'b1;
            if (sh_last) begin st_n = ST_LESU; t_val = TW'(LESU_C - 1); end
            else begin
               st_n = ST_SLOW; t_val = TW'(LO_C - 1); sh_shift = 1'b1;
            end
         end
         ST_LESU: if (t_exp) begin
            st_n = ST_LEHI; t_load = 1'b1; t_val = TW'(SLE_C - 1);
         end
         ST_PSU: if (t_exp) begin
            st_n = ST_LEHI; t_load = 1'b1; t_val = TW'(PLE_C - 1);
         end
         ST_LEHI: if (t_exp) begin
            if (mode_par_q) begin
               st_n = ST_PHOLD; t_load = 1'b1; t_val = TW'(PHD_C - 1);
            end else if (gap_q) begin
               st_n = ST_GAP; t_load = 1'b1; t_val = TW'(GAP_C - 1);
            end else st_n = ST_IDLE;
         end
         ST_PHOLD: if (t_exp) begin
            if (gap_q) begin
               st_n = ST_GAP; t_load = 1'b1; t_val = TW'(GAP_C - 1);
            end else st_n = ST_IDLE;
         end
         ST_GAP: if (t_exp) st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         mode_par_q <= 1'b0;
         gap_q      <= 1'b0;
         sclk_q     <= 1'b0;
         le_q       <= 1'b0;
      end else begin
         st     <= st_n;
         sclk_q <= (st_n == ST_SHIGH);
         le_q   <= (st_n == ST_LEHI);
         if (accept) begin
            mode_par_q <= par_eff;
            gap_q      <= cfg_gap_en;
         end
      end
   end

   atten_span_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   atten_bit_shifter #(.W(CODE_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sh_load),
      .code    (req_code),
      .shift   (sh_shift),
      .bit_out (ser_data),
      .last    (sh_last)
   );

   assign ser_clk  = sclk_q;
   assign latch_en = le_q;
endmodule

// File: rtl/atten_prog_checker.sv
module atten_prog_checker #(
   parameter int CW      = 6,
   parameter int HI_CYC  = 2,
   parameter int LO_CYC  = 3,
   parameter int GAP_CYC = 2000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          cfg_gap_en,
   input logic          ser_clk,
   input logic          ser_data,
   input logic          latch_en,
   input logic [CW-1:0] par_bus
);
   logic [15:0] hi_run, lo_run;
   logic [31:0] since_fall;
   logic        le_d, gap_cur, gap_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run     <= '0;
         lo_run     <= '1;
         since_fall <= '1;
         le_d       <= 1'b0;
         gap_cur    <= 1'b0;
         gap_prev   <= 1'b0;
      end else begin
         le_d <= latch_en;
         if (ser_clk) hi_run <= (hi_run == '1) ? hi_run : hi_run + 16'd1;
         else         hi_run <= '0;
         if (!ser_clk) lo_run <= (lo_run == '1) ? lo_run : lo_run + 16'd1;
         else          lo_run <= '0;
         if (le_d && !latch_en) since_fall <= 32'd1;
         else if (since_fall != '1) since_fall <= since_fall + 32'd1;
         if (req_valid && req_ready) gap_cur <= cfg_gap_en;
         if (le_d && !latch_en) gap_prev <= gap_cur;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!ser_clk && !latch_en));

   assert_busy_from_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> $past(req_valid));

   assert_sclk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> (int'(hi_run) >= HI_CYC));

   assert_sclk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> (int'(lo_run) >= LO_CYC));

   assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_data));

   assert_le_low_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> !latch_en);

   assert_le_after_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_en) |-> (!ser_clk && $past(!ser_clk)));

   assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en || $fell(latch_en)) |-> $stable(par_bus));

   assert_update_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(latch_en) && gap_prev) |-> (since_fall >= 32'(GAP_CYC)));
endmodule

bind atten_prog_master atten_prog_checker #(
   .CW      (CODE_W),
   .HI_CYC  (HI_C),
   .LO_CYC  (LO_C),
   .GAP_CYC (GAP_C)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .cfg_gap_en (cfg_gap_en),
   .ser_clk    (ser_clk),
   .ser_data   (ser_data),
   .latch_en   (latch_en),
   .par_bus    (par_bus)
);

// File: tb/atten_prog_master_tb.sv
module atten_prog_master_tb;
   // cycle counts at a 20 ns clock, from the requirement times rounded up
   localparam int HI_N   = 2;    // 30 ns high
   localparam int LO_N   = 3;    // 100 ns period minus high
   localparam int LESU_N = 1;    // 10 ns latch setup
   localparam int SLE_N  = 2;    // 30 ns serial latch pulse
   localparam int PSU_N  = 1;    // 10 ns bus setup
   localparam int PLE_N  = 1;    // 10 ns parallel latch pulse
   localparam int PHD_N  = 1;    // 10 ns bus hold
   localparam int GAP_N  = 2000; // 40 us hold-off
   localparam int WD_LIM = 150000;

   typedef struct packed {
      logic       sclk;
      logic       sdata;
      logic       le;
      logic [5:0] bus;
      logic       rdy;
      logic       par;
      logic       gap;
      logic       idle;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [5:0] req_code = '0;
   logic       cfg_parallel = 1'b0;
   logic       cfg_gap_en = 1'b0;
   logic       req_ready, ser_clk, ser_data, latch_en;
   logic [5:0] par_bus;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   atten_prog_master u_dut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_code (req_code),
      .cfg_parallel (cfg_parallel), .cfg_gap_en (cfg_gap_en), .req_ready (req_ready),
      .ser_clk (ser_clk), .ser_data (ser_data), .latch_en (latch_en), .par_bus (par_bus)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // ---------------- reference model ----------------
   exp_t       q[$];
   logic       last_sd = 1'b0;
   logic [5:0] last_bus = '0;
   logic [5:0] cur_code = '0;
   logic       cur_par = 1'b0;

   task automatic put(input logic s, input logic d, input logic l, input logic [5:0] b,
                      input logic p, input logic g, input int n);
      exp_t e;
      e = '{sclk:s, sdata:d, le:l, bus:b, rdy:1'b0, par:p, gap:g, idle:1'b0};
      for (int k = 0; k < n; k++) q.push_back(e);
   endtask

   task automatic build(input logic [5:0] c, input logic p, input logic g);
      cur_code = c;
      cur_par  = p;
      if (!p) begin
         for (int i = 5; i >= 0; i--) begin
            put(1'b0, c[i], 1'b0, last_bus, p, g, LO_N);
            put(1'b1, c[i], 1'b0, last_bus, p, g, HI_N);
         end
         put(1'b0, c[0], 1'b0, last_bus, p, g, LESU_N);
         put(1'b0, c[0], 1'b1, last_bus, p, g, SLE_N);
         if (g) put(1'b0, c[0], 1'b0, last_bus, p, g, GAP_N);
      end else begin
         put(1'b0, last_sd, 1'b0, c, p, g, PSU_N);
         put(1'b0, last_sd, 1'b1, c, p, g, PLE_N);
         put(1'b0, last_sd, 1'b0, c, p, g, PHD_N);
         if (g) put(1'b0, last_sd, 1'b0, c, p, g, GAP_N);
      end
   endtask

   always @(negedge clk) begin
      exp_t e;
      if (!rst_n) begin
         q.delete();
         last_sd  = 1'b0;
         last_bus = '0;
      end else if (!done) begin
         if (q.size() != 0) e = q.pop_front();
         else e = '{sclk:1'b0, sdata:last_sd, le:1'b0, bus:last_bus, rdy:1'b1,
                    par:1'b0, gap:1'b0, idle:1'b1};
         total++;
         if (ser_clk !== e.sclk || ser_data !== e.sdata || latch_en !== e.le ||
             par_bus !== e.bus || req_ready !== e.rdy) begin
            bad++;
            if (ser_clk !== e.sclk)
               $display("FAIL %s ser_clk actual=%0d expected=%0d", e.par ? "R8" : "R4", ser_clk, e.sclk);
            if (ser_data !== e.sdata)
               $display("FAIL %s ser_data actual=%0d expected=%0d", e.par ? "R12" : "R3", ser_data, e.sdata);
            if (latch_en !== e.le)
               $display("FAIL %s latch_en actual=%0d expected=%0d", e.par ? "R8" : "R7", latch_en, e.le);
            if (par_bus !== e.bus)
               $display("FAIL %s par_bus actual=%0d expected=%0d", e.par ? "R8" : "R12", par_bus, e.bus);
            if (req_ready !== e.rdy)
               $display("FAIL %s req_ready actual=%0d expected=%0d",
                        e.idle ? "R10" : (e.gap ? "R9" : "R2"), req_ready, e.rdy);
         end
         last_sd  = e.sdata;
         last_bus = e.bus;
         if (req_valid && e.rdy) build(req_code, cfg_parallel, cfg_gap_en);
      end
   end

   // ---------------- pin monitors ----------------
   logic       prev_sclk = 1'b0, prev_le = 1'b0, prev_sd = 1'b0;
   logic [5:0] desh = '0;
   int         nbits = 0;
   bit         len_on = 0;
   int         glen = 0;
   int         last_len = -1;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (ser_clk && !prev_sclk) begin
            desh  = {desh[4:0], ser_data};
            nbits++;
         end
         if (ser_clk) chk(ser_data === prev_sd, "R5", ser_data, prev_sd);
         if (latch_en && !prev_le) begin
            if (!cur_par) begin
               chk(nbits == 6, "R3", nbits, 6);
               chk(desh == cur_code, "R3", desh, cur_code);
            end else begin
               chk(nbits == 0, "R8", nbits, 0);
               chk(par_bus == cur_code, "R8", par_bus, cur_code);
            end
            nbits = 0;
         end
         if (prev_le && !latch_en) begin
            len_on = 1;
            glen   = 0;
         end
         if (len_on) begin
            if (!req_ready) glen++;
            else begin
               len_on   = 0;
               last_len = glen;
            end
         end
      end
      prev_sclk = ser_clk;
      prev_le   = latch_en;
      prev_sd   = ser_data;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIM && !done) begin
         bad++;
         total++;
         $display("FAIL R2 watchdog cycles=%0d expected<=%0d", cyc, WD_LIM);
         finish_run();
      end
   end

   // ---------------- stimulus ----------------
   task automatic send(input logic [5:0] c, input logic p, input logic g);
      @(posedge clk);
      #2;
      req_valid    = 1'b1;
      req_code     = c;
      cfg_parallel = p;
      cfg_gap_en   = g;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #2;
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (q.size() != 0 || !req_ready) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready === 1'b1, "R1", req_ready, 1);
      chk(ser_clk === 1'b0, "R1", ser_clk, 0);
      chk(latch_en === 1'b0, "R1", latch_en, 0);
      chk(ser_data === 1'b0, "R1", ser_data, 0);
      chk(par_bus === 6'd0, "R1", par_bus, 0);

      // serial, no hold-off: ready back in the latch-fall cycle (R3, R10)
      send(6'b101101, 1'b0, 1'b0);
      wait_done();
      chk(last_len == 0, "R10", last_len, 0);

      // back-to-back: second request stalls while busy (R2)
      send(6'b000001, 1'b0, 1'b0);
      send(6'b100000, 1'b0, 1'b0);
      wait_done();
      chk(par_bus === 6'd0, "R12", par_bus, 0);

      // latched parallel, no hold-off: one hold cycle (R8, R10)
      send(6'b110011, 1'b1, 1'b0);
      wait_done();
      chk(last_len == PHD_N, "R10", last_len, PHD_N);
      chk(ser_data === 1'b0, "R12", ser_data, 0);

      // parallel with hold-off (R9)
      send(6'b010101, 1'b1, 1'b1);
      wait_done();
      chk(last_len == PHD_N + GAP_N, "R9", last_len, PHD_N + GAP_N);

      // serial with hold-off (R9)
      send(6'b111111, 1'b0, 1'b1);
      wait_done();
      chk(last_len == GAP_N, "R9", last_len, GAP_N);

      // request stalled across a hold-off, then mode switch (R2, R9)
      send(6'b011110, 1'b0, 1'b1);
      send(6'b100001, 1'b1, 1'b0);
      wait_done();
      chk(par_bus === 6'b100001, "R8", par_bus, 6'b100001);

      // inputs disturbed while busy (R11)
      send(6'b001100, 1'b0, 1'b0);
      req_code     = 6'b110110;
      cfg_parallel = 1'b1;
      cfg_gap_en   = 1'b1;
      wait_done();
      chk(last_len == 0, "R11", last_len, 0);
      chk(par_bus === 6'b100001, "R11", par_bus, 6'b100001);

      // all-zero code in serial
      send(6'b000000, 1'b0, 1'b0);
      wait_done();
      chk(ser_data === 1'b0, "R3", ser_data, 0);

      finish_run();
   end
endmodule